// File: doc/BRIEF.md
# Fault Latch and Release Supervisor

This block watches the digital trip flags of a three-phase inverter gate driver. The flags are overcurrent per phase, desaturation or driver-supply droop per phase, DC-link overvoltage, over-temperature and logic-supply undervoltage. Any accepted trip is latched into a single gate-inhibit output, which forces every gate drive off. The block also keeps one sticky indicator per trip source. It drives annunciation outputs as well: one per phase for current trips, and one shared output for the three system-level trips.

The overvoltage and over-temperature flags are slow faults. A slow fault must stay present for longer than a qualification window before it is accepted. After acceptance, the inhibit waits a fixed arming delay before it takes effect. The overcurrent, desaturation and logic-undervoltage flags are fast faults and latch on the next clock edge.

There is no reset pin for the latch. It is released only when all six PWM commands have been held low for a quiet window and no trip cause remains. A side effect follows from this and is kept on purpose: if the command stream itself contains low gaps at least as long as the quiet window, the latch is released inside those gaps. All times are counts of clock cycles.

Top module: `fault_latch_supervisor`

## Requirements
- R1: After reset, the inhibit, every indicator and every annunciation output are low.
- R2: A high overcurrent flag on phase p, or a high logic-undervoltage flag, sets its own indicator and the inhibit at the first clock edge that samples it.
- R3: A desaturation flag on phase p lights the phase-p current indicator, the same indicator that overcurrent uses, and sets the inhibit at the first sampling edge.
- R4: An overvoltage or over-temperature flag is accepted at the edge where it has been sampled high on QUAL_CYC+1 consecutive edges. Its indicator and the inhibit are set ARM_CYC edges after acceptance, even if the flag drops in between.
- R5: A slow flag that is sampled high on QUAL_CYC or fewer consecutive edges restarts its qualification, and nothing is latched.
- R6: Phase alarm output p equals phase indicator p. The shared system alarm is high when any of the overvoltage, over-temperature or undervoltage indicators is lit.
- R7: Indicators are sticky. They stay lit after their flag drops, and a second trip adds its own indicator without removing the first.
- R8: With no trip cause present, the latch and all indicators clear at the edge that samples all six commands low for the (QUIET_CYC+1)-th consecutive time. They are still set one edge before that.
- R9: If a trip cause is still present when the quiet window completes, the latch holds. It then clears at the first edge that samples the cause gone while the commands are still low.
- R10: Any command sampled high restarts the quiet count from zero, whichever of the six commands it is.
- R11: A command stream with low gaps of QUIET_CYC sampled edges never releases the latch. A gap of QUIET_CYC+1 sampled edges releases it inside the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_cmd_i | input | 2*N_PHASE | Upper and lower switch commands, high means on |
| oc_flag_i | input | N_PHASE | Per-phase overcurrent comparator flag |
| desat_flag_i | input | N_PHASE | Per-phase desaturation or driver-supply droop flag |
| dc_ov_flag_i | input | 1 | DC-link overvoltage comparator flag |
| over_temp_flag_i | input | 1 | Over-temperature comparator flag |
| logic_uv_flag_i | input | 1 | Logic-supply undervoltage flag |
| gate_inhibit_o | output | 1 | Latched inhibit, forces all gate drives off |
| lamp_phase_o | output | N_PHASE | Sticky per-phase current-trip indicator |
| lamp_ov_o | output | 1 | Sticky overvoltage indicator |
| lamp_ot_o | output | 1 | Sticky over-temperature indicator |
| lamp_uv_o | output | 1 | Sticky logic-undervoltage indicator |
| phase_alarm_o | output | N_PHASE | Per-phase current-trip annunciation |
| sys_alarm_o | output | 1 | Shared overvoltage/over-temperature/undervoltage annunciation |

## Verification
Fast trips are due one edge after the flag is driven. Slow trips are due exactly QUAL_CYC+1+ARM_CYC edges after the flag rises, and the release is due at the (QUIET_CYC+1)-th edge that samples all commands low. The bench drives inputs on falling edges and counts rising edges with a tick helper. It samples one edge before each due point, where the old value must still show, and then on the due edge itself, so an off-by-one in any counter shows up as a mismatch. Slow pulse lengths are swept from 1 to QUAL_CYC+1, and each of the six commands in turn is used to break the quiet window.

// File: rtl/fls_pkg.sv
`timescale 1ns/1ps
package fls_pkg;
  // System-level trip sources; their position above the phase bits in the
  // indicator vector is decoded by the annunciation logic.
  localparam int unsigned SYS_SRC = 3;
  typedef enum logic [1:0] {
    SYS_OV = 2'd0,
    SYS_OT = 2'd1,
    SYS_UV = 2'd2
  } sys_src_e;

  function automatic int unsigned lamp_count(input int unsigned n_phase);
    return n_phase + SYS_SRC;
  endfunction
endpackage

// File: rtl/fls_persist_qual.sv
`timescale 1ns/1ps
// Persistence qualifier with arming delay for a slow trip flag.
module fls_persist_qual #(
  parameter int unsigned QUAL_CYC = 200000,
  parameter int unsigned ARM_CYC  = 400000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic fire_o,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(QUAL_CYC + 1);
  localparam int unsigned DW = $clog2(ARM_CYC + 1);
  localparam logic [CW-1:0] RUN_MAX  = CW'(QUAL_CYC);
  localparam logic [DW-1:0] DLY_LAST = DW'(ARM_CYC - 1);

  logic [CW-1:0] run_q, run_d;
  logic [DW-1:0] dly_q, dly_d;
  logic          pend_q, pend_d;
  logic          run_en, arm_en, accept;

  always_comb begin
    accept = flag_i && (run_q == RUN_MAX) && !pend_q;
    fire_o = pend_q && (dly_q == DLY_LAST);
    busy_o = pend_q;

    run_en = flag_i ? (run_q != RUN_MAX) : (run_q != '0);
    run_d  = flag_i ? run_q + 1'b1 : '0;

    arm_en = accept || pend_q;
    pend_d = pend_q;
    dly_d  = dly_q;
    if (accept) begin
      pend_d = 1'b1;
      dly_d  = '0;
    end else if (fire_o) begin
      pend_d = 1'b0;
      dly_d  = '0;
    end else begin
      dly_d  = dly_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      dly_q  <= '0;
    end else if (arm_en) begin
      pend_q <= pend_d;
      dly_q  <= dly_d;
    end
  end

  // R5: a dropped flag restarts the run and cannot start an arming delay
  p_drop_restarts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_i |=> (run_q == '0) && !$rose(pend_q))
    else $error("R5 qualifier advanced on a low flag");

  // R4: acceptance only ever follows a high flag sample
  p_accept_on_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(flag_i))
    else $error("R4 accepted without flag");
endmodule

// File: rtl/fls_quiet_timer.sv
`timescale 1ns/1ps
// Counts consecutive edges with every command low; saturates at QUIET_CYC.
module fls_quiet_timer #(
  parameter int unsigned N_CMD     = 6,
  parameter int unsigned QUIET_CYC = 1600000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CMD-1:0] pwm_i,
  output logic             quiet_o
);
  localparam int unsigned QW = $clog2(QUIET_CYC + 1);
  localparam logic [QW-1:0] QUIET_MAX = QW'(QUIET_CYC);

  logic [QW-1:0] low_q, low_d;
  logic          low_en, any_high;

  always_comb begin
    any_high = |pwm_i;
    low_en   = any_high ? (low_q != '0) : (low_q != QUIET_MAX);
    low_d    = any_high ? '0 : low_q + 1'b1;
    quiet_o  = (low_q == QUIET_MAX) && !any_high;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= '0;
    end else if (low_en) begin
      low_q <= low_d;
    end
  end

  // R10: one high command forbids release on the following cycle
  p_high_restarts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_high |=> !quiet_o)
    else $error("R10 quiet window survived a high command");

  // R8: the window can only be complete after a low sample
  p_quiet_after_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_o |-> $past(!any_high))
    else $error("R8 quiet reported after a high sample");
endmodule

// File: rtl/fls_lamp_bank.sv
`timescale 1ns/1ps
// Sticky per-source indicators with a common clear; set wins over clear.
module fls_lamp_bank #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] lamp_o
);
  logic [W-1:0] lamp_q, lamp_d;
  logic         lamp_en;

  always_comb begin
    lamp_en = clr_i || (set_i != '0);
    lamp_d  = (clr_i ? '0 : lamp_q) | set_i;
    lamp_o  = lamp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lamp_q <= '0;
    end else if (lamp_en) begin
      lamp_q <= lamp_d;
    end
  end

  // R7: without a clear no lit indicator goes dark
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((lamp_q & $past(lamp_q)) == $past(lamp_q)))
    else $error("R7 indicator lost without release");

  // R2: every requested source is lit on the next cycle
  p_set_lights_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((lamp_q & $past(set_i)) == $past(set_i)))
    else $error("R2 indicator not lit");
endmodule

// File: rtl/fault_latch_supervisor.sv
`timescale 1ns/1ps
module fault_latch_supervisor
  import fls_pkg::*;
#(
  parameter int unsigned N_PHASE   = 3,
  parameter int unsigned QUAL_CYC  = 200000,
  parameter int unsigned ARM_CYC   = 400000,
  parameter int unsigned QUIET_CYC = 1600000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2*N_PHASE-1:0] pwm_cmd_i,
  input  logic [N_PHASE-1:0]   oc_flag_i,
  input  logic [N_PHASE-1:0]   desat_flag_i,
  input  logic                 dc_ov_flag_i,
  input  logic                 over_temp_flag_i,
  input  logic                 logic_uv_flag_i,
  output logic                 gate_inhibit_o,
  output logic [N_PHASE-1:0]   lamp_phase_o,
  output logic                 lamp_ov_o,
  output logic                 lamp_ot_o,
  output logic                 lamp_uv_o,
  output logic [N_PHASE-1:0]   phase_alarm_o,
  output logic                 sys_alarm_o
);
  localparam int unsigned N_CMD  = 2 * N_PHASE;
  localparam int unsigned N_LAMP = lamp_count(N_PHASE);
  localparam int unsigned N_SLOW = 2;
  localparam int unsigned IX_OV  = N_PHASE + int'(SYS_OV);
  localparam int unsigned IX_OT  = N_PHASE + int'(SYS_OT);
  localparam int unsigned IX_UV  = N_PHASE + int'(SYS_UV);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [N_SLOW-1:0] slow_flag, slow_fire, slow_busy;
  logic [N_LAMP-1:0] lamp_set, lamp;
  logic              quiet, cause, release_ok;

  assign slow_flag = {over_temp_flag_i, dc_ov_flag_i};

  for (genvar g = 0; g < N_SLOW; g++) begin : g_slow
    fls_persist_qual #(
      .QUAL_CYC (QUAL_CYC),
      .ARM_CYC  (ARM_CYC)
    ) u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .flag_i (slow_flag[g]),
      .fire_o (slow_fire[g]),
      .busy_o (slow_busy[g])
    );
  end

  fls_quiet_timer #(
    .N_CMD     (N_CMD),
    .QUIET_CYC (QUIET_CYC)
  ) u_quiet (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .pwm_i   (pwm_cmd_i),
    .quiet_o (quiet)
  );

  always_comb begin
    lamp_set               = '0;
    lamp_set[N_PHASE-1:0]  = oc_flag_i | desat_flag_i;
    lamp_set[IX_OV]        = slow_fire[0];
    lamp_set[IX_OT]        = slow_fire[1];
    lamp_set[IX_UV]        = logic_uv_flag_i;
    cause      = (|oc_flag_i) || (|desat_flag_i) || logic_uv_flag_i ||
                 (|slow_flag) || (|slow_busy);
    release_ok = quiet && !cause;
  end

  fls_lamp_bank #(
    .W (N_LAMP)
  ) u_lamps (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .set_i  (lamp_set),
    .clr_i  (release_ok),
    .lamp_o (lamp)
  );

  always_comb begin
    lamp_phase_o   = lamp[N_PHASE-1:0];
    lamp_ov_o      = lamp[IX_OV];
    lamp_ot_o      = lamp[IX_OT];
    lamp_uv_o      = lamp[IX_UV];
    gate_inhibit_o = |lamp;
    phase_alarm_o  = lamp[N_PHASE-1:0];
    sys_alarm_o    = lamp[IX_OV] | lamp[IX_OT] | lamp[IX_UV];
  end

  // R2: fast trips inhibit on the next edge
  p_fast_trip_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((|oc_flag_i) || (|desat_flag_i) || logic_uv_flag_i) |=> gate_inhibit_o)
    else $error("R2 fast trip missed");

  // R4: an armed slow trip inhibits on the next edge
  p_slow_trip_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|slow_fire) |=> gate_inhibit_o)
    else $error("R4 slow trip missed");

  // R8: release only follows an all-low command sample
  p_release_low_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(gate_inhibit_o) |-> $past(pwm_cmd_i == '0))
    else $error("R8 release with a command high");

  // R9: release only follows a cause-free sample
  p_release_clean_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(gate_inhibit_o) |-> $past(!((|oc_flag_i) || (|desat_flag_i) ||
      logic_uv_flag_i || dc_ov_flag_i || over_temp_flag_i)))
    else $error("R9 release with a cause present");
endmodule

// File: tb/fault_latch_supervisor_tb_top.sv
`timescale 1ns/1ps
module fault_latch_supervisor_tb_top;
  localparam int unsigned NP = 3;
  localparam int unsigned Q  = 4;
  localparam int unsigned A  = 3;
  localparam int unsigned QT = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [5:0]    pwm;
  logic [2:0]    oc, desat;
  logic          ov, ot, uv;
  logic          inh, l_ov, l_ot, l_uv, s_al;
  logic [2:0]    l_ph, p_al;
  int            total = 0;
  int            fails = 0;
  bit            done  = 1'b0;

  always #2.5 clk = ~clk;

  fault_latch_supervisor #(
    .N_PHASE (NP), .QUAL_CYC (Q), .ARM_CYC (A), .QUIET_CYC (QT)
  ) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .pwm_cmd_i (pwm),
    .oc_flag_i (oc), .desat_flag_i (desat), .dc_ov_flag_i (ov),
    .over_temp_flag_i (ot), .logic_uv_flag_i (uv),
    .gate_inhibit_o (inh), .lamp_phase_o (l_ph), .lamp_ov_o (l_ov),
    .lamp_ot_o (l_ot), .lamp_uv_o (l_uv), .phase_alarm_o (p_al),
    .sys_alarm_o (s_al)
  );

  // {inhibit, sys_alarm, phase_alarm[2:0], uv, ot, ov, phase[2:0]}
  function automatic logic [10:0] obs();
    return {inh, s_al, p_al, l_uv, l_ot, l_ov, l_ph};
  endfunction

  function automatic logic [10:0] build(input logic [2:0] ph,
                                        input logic o_v, o_t, u_v);
    return {(|ph) | o_v | o_t | u_v, o_v | o_t | u_v, ph, u_v, o_t, o_v, ph};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] got, exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clear_flags();
    oc = '0; desat = '0; ov = 1'b0; ot = 1'b0; uv = 1'b0;
  endtask

  // R8: commands go low after at least one high edge; release due at QT+1
  task automatic release_all();
    pwm = 6'b000001;
    tick(1);
    pwm = '0;
    tick(QT);
    chk("R8 still latched one edge early", 16'(inh), 16'd1);
    tick(1);
    chk("R8 released", 16'(obs()), 16'd0);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [10:0] e;
    rst_n = 1'b0; pwm = '0; clear_flags();
    tick(3);
    rst_n = 1'b1;
    tick(3);
    chk("R1 reset state", 16'(obs()), 16'd0);

    // fast trips: oc0..2 (R2), desat0..2 (R3), logic uv (R2)
    for (int s = 0; s < 7; s++) begin
      pwm = 6'(1 << (s % 6));
      tick(1);
      if (s < 3)      oc[s]      = 1'b1;
      else if (s < 6) desat[s-3] = 1'b1;
      else            uv         = 1'b1;
      e = (s < 6) ? build(3'(1 << (s % 3)), 1'b0, 1'b0, 1'b0)
                  : build(3'b000, 1'b0, 1'b0, 1'b1);
      tick(1);
      chk((s >= 3 && s < 6) ? "R3 desat to phase lamp" : "R2 fast trip",
          16'(obs()), 16'(e));
      chk("R6 annunciation", 16'(obs() >> 6), 16'(e >> 6));
      clear_flags();
      tick(2);
      chk("R7 sticky after flag drop", 16'(obs()), 16'(e));
      release_all();
    end

    // slow trips: pulse length sweep (R5 below threshold, R4 at threshold)
    for (int src = 0; src < 2; src++) begin
      for (int len = 1; len <= int'(Q) + 1; len++) begin
        pwm = 6'b000010;
        if (src == 0) ov = 1'b1; else ot = 1'b1;
        tick(len);
        clear_flags();
        tick(A + 2);
        if (len <= int'(Q)) begin
          chk("R5 short slow pulse ignored", 16'(obs()), 16'd0);
        end else begin
          e = build(3'b000, src == 0, src == 1, 1'b0);
          chk("R4 accepted slow trip latches", 16'(obs()), 16'(e));
          release_all();
        end
      end
      // exact latency with a held flag
      pwm = 6'b000100;
      if (src == 0) ov = 1'b1; else ot = 1'b1;
      tick(Q + A);
      chk("R4 not yet latched", 16'(obs()), 16'd0);
      tick(1);
      e = build(3'b000, src == 0, src == 1, 1'b0);
      chk("R4 latched on due edge", 16'(obs()), 16'(e));
      chk("R6 shared alarm", 16'(s_al), 16'd1);
      clear_flags();
      release_all();
    end

    // R5: interrupted runs of Q edges never accumulate
    pwm = 6'b000001;
    for (int k = 0; k < 3; k++) begin
      ov = 1'b1; tick(Q); ov = 1'b0; tick(1);
    end
    tick(A + 1);
    chk("R5 interrupted runs ignored", 16'(obs()), 16'd0);

    // R7: accumulation of two sources
    oc[0] = 1'b1; tick(1); oc[0] = 1'b0;
    ot = 1'b1; tick(Q + A + 1); ot = 1'b0;
    tick(1);
    chk("R7 second source added", 16'(obs()), 16'(build(3'b001, 1'b0, 1'b1, 1'b0)));
    release_all();

    // R9: cause held through the quiet window
    pwm = 6'b001000; oc[1] = 1'b1;
    tick(1);
    pwm = '0;
    tick(QT + 3);
    chk("R9 latch held with cause", 16'(obs()), 16'(build(3'b010, 1'b0, 1'b0, 1'b0)));
    oc[1] = 1'b0;
    tick(1);
    chk("R9 released when cause gone", 16'(obs()), 16'd0);

    // R10: each command in turn breaks the window
    for (int b = 0; b < 6; b++) begin
      pwm = 6'b000001; desat[2] = 1'b1; tick(1); desat[2] = 1'b0;
      pwm = '0;
      tick(QT - 1);
      pwm = 6'(1 << b);
      tick(1);
      pwm = '0;
      tick(QT);
      chk("R10 restart, still latched", 16'(inh), 16'd1);
      tick(1);
      chk("R10 released after fresh window", 16'(inh), 16'd0);
    end

    // R11: gaps of QT edges hold, a gap of QT+1 edges releases
    pwm = 6'b010000; uv = 1'b1; tick(1); uv = 1'b0;
    for (int k = 0; k < 3; k++) begin
      pwm = 6'b010000; tick(2);
      pwm = '0; tick(QT);
      chk("R11 gap of window length holds", 16'(inh), 16'd1);
    end
    pwm = 6'b100000; tick(2);
    pwm = '0; tick(QT + 1);
    chk("R11 longer gap releases", 16'(obs()), 16'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule